// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Access-Driven Flag Clearing

A 16-bit up-counter, advanced by a power-of-two divider from the bus clock, with an overflow flag and eight capture/compare channels. Each channel holds a 16-bit value register. In compare mode a channel raises its flag when the counter reaches that value. In capture mode a strobe latches the counter into the register and raises the flag. The overflow flag, gated by an enable bit, drives an interrupt request.

All state is reached through a byte-wide register bus with an address, a read strobe and a write strobe. `bus_rdata` always shows the addressed register. The strobes matter only for writes and for side effects. Flags are normally cleared by writing ones to them. A fast-clear option lets the ordinary data accesses clear the related flag instead, so an interrupt handler does not need a separate clear step.

Two further options are provided. The counter can be returned to zero on a match of the highest channel. The counter can also be frozen while a debug or wait indication is active.

Register map (byte offsets, 6-bit address):
- 0x04 counter high byte, 0x05 counter low byte.
- 0x06 control A: bit7 run, bit6 halt while `wait_mode`, bit5 halt while `dbg_mode`, bit4 fast-clear.
- 0x0C channel direction: bit n = 1 selects compare, 0 selects capture.
- 0x0D control B: bit7 overflow interrupt enable, bit3 restart on top-channel match, bits2:0 prescale exponent.
- 0x0E channel flags (bit n).
- 0x0F overflow flag (bit7).
- 0x10+2n channel n value high byte, 0x11+2n low byte.

Top module: `pstm_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_ovf` is low.
- R2: While running, the counter advances by one every 2^P clock cycles, where P is control B bits2:0.
- R3: When the counter advances from 0xFFFF it wraps to zero and sets the overflow flag (offset 0x0F bit7).
- R4: `irq_ovf` is high exactly when the overflow flag and control B bit7 are both set.
- R5: Writing a 1 to a flag bit at 0x0E or 0x0F clears that flag. Writing 0 leaves it unchanged.
- R6: With control A bit4 set, any read or write of 0x04 or 0x05 clears the overflow flag.
- R7: With control A bit4 set, reading either byte of a capture channel, or writing either byte of a compare channel, clears that channel's flag.
- R8: With control A bit4 clear, counter and channel accesses leave all flags unchanged. With it set, a read of a compare channel or a write of a capture channel also leaves its flag unchanged.
- R9: Writes to 0x04/0x05 change the counter byte only while `special_mode` is high. Otherwise they are ignored.
- R10: With control B bit3 set, a compare match on the highest channel (channel 7) returns the counter to zero instead of advancing it.
- R11: A compare channel sets its flag on a counter advance that starts at its value. A capture channel latches the counter and sets its flag on its `cap_strobe` bit.
- R12: When a flag set event and a clear of that flag occur in the same cycle, the flag ends up set.
- R13: The counter and divider hold while `dbg_mode` is high with control A bit5 set, or while `wait_mode` is high with bit6 set.
- R14: With control A bit7 clear, the counter holds and the divider is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte offset |
| bus_rd | input | 1 | Read strobe (fast-clear side effects only) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Contents of the addressed register |
| cap_strobe | input | NCH | Per-channel capture request |
| dbg_mode | input | 1 | Debug halt indication |
| wait_mode | input | 1 | Wait halt indication |
| special_mode | input | 1 | Permits counter writes |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The bench goes after the clear paths, because they are the easiest to get wrong:
- A fast-clear decode that ignores the channel direction would wipe a compare flag on a read. The bench reads a compare channel and expects the flag to stay set.
- A design that lets the clear win over a coincident event would drop a capture. The bench strikes a capture and a write-one clear in the same cycle.
- Other corner cases are the wrap from 0xFFFF, restart on the top channel (a wrong design lets the counter run past the match value), counter writes outside special mode, and the two freeze sources.

A behavioural model tracks every register and is compared with the read data and the interrupt on every clock.

// File: rtl/pstm_pkg.sv
package pstm_pkg;
   localparam int ADDR_W = 6;

   localparam logic [ADDR_W-1:0] A_CNT_HI  = 6'h04;
   localparam logic [ADDR_W-1:0] A_CNT_LO  = 6'h05;
   localparam logic [ADDR_W-1:0] A_CTLA    = 6'h06;
   localparam logic [ADDR_W-1:0] A_DIR     = 6'h0C;
   localparam logic [ADDR_W-1:0] A_CTLB    = 6'h0D;
   localparam logic [ADDR_W-1:0] A_CHFLG   = 6'h0E;
   localparam logic [ADDR_W-1:0] A_OVFLG   = 6'h0F;
   localparam logic [ADDR_W-1:0] A_CH_BASE = 6'h10;

   typedef struct packed {
      logic run;
      logic wait_halt;
      logic dbg_halt;
      logic fast_clr;
   } ctla_t;
endpackage

// File: rtl/pstm_prescale.sv
module pstm_prescale #(
   parameter int PR_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_i,
   input  logic            run_i,
   input  logic [PR_W-1:0] pr_i,
   output logic            tick_o
);
   localparam int DIV_W = (1 << PR_W) - 1;

   logic [DIV_W-1:0] pre_q;
   logic [DIV_W-1:0] mask;

   always_comb begin
      mask   = ~({DIV_W{1'b1}} << pr_i);
      tick_o = run_i && ((pre_q & mask) == mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pre_q <= '0;
      else if (!en_i) pre_q <= '0;
      else if (run_i) pre_q <= pre_q + DIV_W'(1);
   end

   // R14: a stopped timer leaves the divider cleared
   a_r14_divider_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (pre_q == '0));
   // R13: a halted timer keeps its divider phase
   a_r13_divider_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !run_i) |=> $stable(pre_q));
endmodule

// File: rtl/pstm_count.sv
module pstm_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic             ld_hi_i,
   input  logic             ld_lo_i,
   input  logic [7:0]       ld_data_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (ld_hi_i)  cnt_q <= {ld_data_i[CNT_W-9:0], cnt_q[7:0]};
      else if (ld_lo_i)  cnt_q <= {cnt_q[CNT_W-1:8], ld_data_i};
      else if (tick_i)   cnt_q <= restart_i ? '0 : cnt_q + CNT_W'(1);
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = tick_i && (cnt_q == '1);

   // R9: without a load or a tick the counter does not move
   a_r9_counter_still: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !ld_hi_i && !ld_lo_i) |=> $stable(cnt_q));
   // R3: advancing from all ones lands on zero
   a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ld_hi_i && !ld_lo_i && cnt_q == '1) |=> (cnt_q == '0));
   // R10: a restart request on a tick clears the counter
   a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && restart_i && !ld_hi_i && !ld_lo_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pstm_chan.sv
module pstm_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_mode_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             cap_i,
   input  logic             wr_hi_i,
   input  logic             wr_lo_i,
   input  logic [7:0]       wdata_i,
   output logic [CNT_W-1:0] val_o,
   output logic             event_o
);
   logic [CNT_W-1:0] val_q;
   logic             do_cap;

   assign do_cap  = cap_i && !cmp_mode_i;
   assign event_o = cmp_mode_i ? (tick_i && (cnt_i == val_q)) : cap_i;
   assign val_o   = val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       val_q <= '0;
      else if (do_cap)  val_q <= cnt_i;
      else if (wr_hi_i) val_q <= {wdata_i[CNT_W-9:0], val_q[7:0]};
      else if (wr_lo_i) val_q <= {val_q[CNT_W-1:8], wdata_i};
   end

   // R11: a capture strobe in capture mode takes the counter value
   a_r11_capture_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && !cmp_mode_i) |=> (val_q == $past(cnt_i)));
endmodule

// File: rtl/pstm_timer.sv
module pstm_timer #(
   parameter int NCH   = 8,
   parameter int CNT_W = 16,
   parameter int PR_W  = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [5:0]     bus_addr,
   input  logic           bus_rd,
   input  logic           bus_wr,
   input  logic [7:0]     bus_wdata,
   output logic [7:0]     bus_rdata,
   input  logic [NCH-1:0] cap_strobe,
   input  logic           dbg_mode,
   input  logic           wait_mode,
   input  logic           special_mode,
   output logic           irq_ovf
);
   import pstm_pkg::*;

   localparam int TOP_CH = NCH - 1;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("pstm_timer: NCH must lie in 1..8");
   end
   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
      $error("pstm_timer: CNT_W must lie in 9..16");
   end
   if (PR_W < 1 || PR_W > 3) begin : g_bad_pr
      $error("pstm_timer: PR_W must lie in 1..3");
   end

   ctla_t            ctla_q;
   logic             ie_q, restart_en_q;
   logic [PR_W-1:0]  pr_q;
   logic [NCH-1:0]   dir_q, chf_q, chf_d;
   logic             ovf_q, ovf_d;

   logic             running, tick, wrap;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] val_w [NCH];
   logic [NCH-1:0]   ch_event, hit_hi, hit_lo;
   logic             acc, cnt_hit, ovf_clr, restart;

   assign acc     = bus_rd || bus_wr;
   assign cnt_hit = (bus_addr == A_CNT_HI) || (bus_addr == A_CNT_LO);
   assign running = ctla_q.run && !(wait_mode && ctla_q.wait_halt)
                                && !(dbg_mode && ctla_q.dbg_halt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctla_q       <= '0;
         ie_q         <= 1'b0;
         restart_en_q <= 1'b0;
         pr_q         <= '0;
         dir_q        <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_CTLA) ctla_q <= ctla_t'(bus_wdata[7:4]);
         if (bus_addr == A_DIR)  dir_q  <= bus_wdata[NCH-1:0];
         if (bus_addr == A_CTLB) begin
            ie_q         <= bus_wdata[7];
            restart_en_q <= bus_wdata[3];
            pr_q         <= bus_wdata[PR_W-1:0];
         end
      end
   end

   pstm_prescale #(.PR_W(PR_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (ctla_q.run),
      .run_i  (running),
      .pr_i   (pr_q),
      .tick_o (tick)
   );

   assign restart = restart_en_q && dir_q[TOP_CH] && ch_event[TOP_CH];

   pstm_count #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .restart_i (restart),
      .ld_hi_i   (special_mode && bus_wr && bus_addr == A_CNT_HI),
      .ld_lo_i   (special_mode && bus_wr && bus_addr == A_CNT_LO),
      .ld_data_i (bus_wdata),
      .cnt_o     (cnt_w),
      .wrap_o    (wrap)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam logic [5:0] HI = A_CH_BASE + 6'(2 * n);
      logic fclr, wclr;

      assign hit_hi[n] = (bus_addr == HI);
      assign hit_lo[n] = (bus_addr == HI + 6'd1);

      pstm_chan #(.CNT_W(CNT_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .cmp_mode_i (dir_q[n]),
         .tick_i     (tick),
         .cnt_i      (cnt_w),
         .cap_i      (cap_strobe[n]),
         .wr_hi_i    (bus_wr && hit_hi[n]),
         .wr_lo_i    (bus_wr && hit_lo[n]),
         .wdata_i    (bus_wdata),
         .val_o      (val_w[n]),
         .event_o    (ch_event[n])
      );

      assign fclr = ctla_q.fast_clr && (hit_hi[n] || hit_lo[n])
                    && ((bus_rd && !dir_q[n]) || (bus_wr && dir_q[n]));
      assign wclr = bus_wr && (bus_addr == A_CHFLG) && bus_wdata[n];
      assign chf_d[n] = ch_event[n] || (chf_q[n] && !(fclr || wclr));

      // R12: an event always leaves its flag set
      a_r12_chan_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         ch_event[n] |=> chf_q[n]);
   end

   assign ovf_clr = (bus_wr && bus_addr == A_OVFLG && bus_wdata[7])
                    || (ctla_q.fast_clr && acc && cnt_hit);
   assign ovf_d   = wrap || (ovf_q && !ovf_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chf_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         chf_q <= chf_d;
         ovf_q <= ovf_d;
      end
   end

   assign irq_ovf = ovf_q && ie_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CNT_HI: bus_rdata = 8'(cnt_w[CNT_W-1:8]);
         A_CNT_LO: bus_rdata = cnt_w[7:0];
         A_CTLA:   bus_rdata = {ctla_q, 4'b0};
         A_DIR:    bus_rdata = 8'(dir_q);
         A_CTLB:   bus_rdata = {ie_q, 3'b0, restart_en_q, 3'(pr_q)};
         A_CHFLG:  bus_rdata = 8'(chf_q);
         A_OVFLG:  bus_rdata = {ovf_q, 7'b0};
         default: begin
            for (int n = 0; n < NCH; n++) begin
               if (hit_hi[n]) bus_rdata = 8'(val_w[n][CNT_W-1:8]);
               if (hit_lo[n]) bus_rdata = val_w[n][7:0];
            end
         end
      endcase
   end

   // R3: a wrap always leaves the overflow flag set
   a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_q);
   // R8: with no bus access and no wrap the overflow flag is untouched
   a_r8_ovf_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap && !acc) |=> $stable(ovf_q));
endmodule

// File: tb/pstm_timer_tb.sv
module pstm_timer_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] addr = '0;
   logic       rd = 1'b0, wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] cap = '0;
   logic       dbg = 1'b0, wt = 1'b0, spc = 1'b0;
   logic       irq;

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD / 2) clk = ~clk;

   pstm_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
      .bus_wdata(wdata), .bus_rdata(rdata), .cap_strobe(cap),
      .dbg_mode(dbg), .wait_mode(wt), .special_mode(spc), .irq_ovf(irq)
   );

   // ---------------- behavioural reference ----------------
   logic [15:0] m_cnt, m_val [8];
   logic [6:0]  m_pre;
   logic [7:0]  m_ca, m_cb, m_dir, m_cf;
   logic        m_ovf;
   logic [15:0] n_cnt, n_val [8];
   logic [7:0]  n_cf, ev;
   logic        run, tick, wrapev, oclr, fclr, wclr;
   logic [6:0]  mask;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_ca = 0; m_cb = 0; m_dir = 0; m_cf = 0; m_ovf = 0;
         for (int n = 0; n < 8; n++) m_val[n] = 0;
      end else begin
         run    = m_ca[7] && !(wt && m_ca[6]) && !(dbg && m_ca[5]);
         mask   = 7'((1 << m_cb[2:0]) - 1);
         tick   = run && ((m_pre & mask) == mask);
         wrapev = tick && (m_cnt == 16'hFFFF);
         for (int n = 0; n < 8; n++)
            ev[n] = m_dir[n] ? (tick && m_cnt == m_val[n]) : cap[n];
         n_cnt = m_cnt;
         if (spc && wr && addr == 6'h04)      n_cnt = {wdata, m_cnt[7:0]};
         else if (spc && wr && addr == 6'h05) n_cnt = {m_cnt[15:8], wdata};
         else if (tick) n_cnt = (m_cb[3] && m_dir[7] && m_cnt == m_val[7]) ? 16'h0 : m_cnt + 16'h1;
         oclr = (wr && addr == 6'h0F && wdata[7]) ||
                (m_ca[4] && (rd || wr) && (addr == 6'h04 || addr == 6'h05));
         for (int n = 0; n < 8; n++) begin
            fclr = m_ca[4] && (addr == 6'(16 + 2 * n) || addr == 6'(17 + 2 * n)) &&
                   ((rd && !m_dir[n]) || (wr && m_dir[n]));
            wclr = wr && addr == 6'h0E && wdata[n];
            n_cf[n] = ev[n] || (m_cf[n] && !(fclr || wclr));
            n_val[n] = m_val[n];
            if (!m_dir[n] && cap[n]) n_val[n] = m_cnt;
            else if (wr && addr == 6'(16 + 2 * n)) n_val[n] = {wdata, m_val[n][7:0]};
            else if (wr && addr == 6'(17 + 2 * n)) n_val[n] = {m_val[n][15:8], wdata};
         end
         if (!m_ca[7]) m_pre = 0;
         else if (run) m_pre = m_pre + 7'd1;
         m_ovf = wrapev || (m_ovf && !oclr);
         m_cnt = n_cnt;
         m_cf  = n_cf;
         for (int n = 0; n < 8; n++) m_val[n] = n_val[n];
         if (wr && addr == 6'h06) m_ca  = wdata & 8'hF0;
         if (wr && addr == 6'h0C) m_dir = wdata;
         if (wr && addr == 6'h0D) m_cb  = wdata & 8'h8F;
      end
   end

   function automatic logic [7:0] m_read(input logic [5:0] a);
      logic [7:0] r;
      r = 0;
      case (a)
         6'h04: r = m_cnt[15:8];
         6'h05: r = m_cnt[7:0];
         6'h06: r = m_ca;
         6'h0C: r = m_dir;
         6'h0D: r = m_cb;
         6'h0E: r = m_cf;
         6'h0F: r = {m_ovf, 7'b0};
         default: for (int n = 0; n < 8; n++) begin
            if (a == 6'(16 + 2 * n)) r = m_val[n][15:8];
            if (a == 6'(17 + 2 * n)) r = m_val[n][7:0];
         end
      endcase
      return r;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // every-clock comparison against the reference
   always @(posedge clk) begin
      #1;
      check({cur_req, " model rdata"}, 16'(rdata), 16'(m_read(addr)));
      check({cur_req, " model irq"}, 16'(irq), 16'(m_ovf && m_cb[7]));
   end

   // ---------------- bus tasks ----------------
   task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; rd = 1'b1; #1; v = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic rd_chk(input logic [5:0] a, input logic [7:0] msk,
                         input logic [7:0] exp, input string tag);
      logic [7:0] v;
      bus_read(a, v);
      check(tag, 16'(v & msk), 16'(exp));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_cnt(input logic [15:0] v);
      spc = 1'b1;
      bus_write(6'h04, v[15:8]);
      bus_write(6'h05, v[7:0]);
      spc = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] a, b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      cur_req = "R1";
      rd_chk(6'h06, 8'hFF, 8'h00, "R1 control A after reset");
      rd_chk(6'h0F, 8'hFF, 8'h00, "R1 overflow flag after reset");
      rd_chk(6'h04, 8'hFF, 8'h00, "R1 counter after reset");
      check("R1 irq after reset", 16'(irq), 16'h0);

      cur_req = "R9";
      bus_write(6'h04, 8'h12);
      rd_chk(6'h04, 8'hFF, 8'h00, "R9 counter write ignored in normal mode");
      load_cnt(16'hFFF0);
      rd_chk(6'h04, 8'hFF, 8'hFF, "R9 special-mode high byte");
      rd_chk(6'h05, 8'hFF, 8'hF0, "R9 special-mode low byte");

      cur_req = "R14";
      idle(10);
      rd_chk(6'h05, 8'hFF, 8'hF0, "R14 stopped counter holds");

      cur_req = "R3";
      bus_write(6'h0D, 8'h80);
      bus_write(6'h06, 8'h80);
      idle(30);
      check("R4 irq with enable", 16'(irq), 16'h1);
      rd_chk(6'h0F, 8'hFF, 8'h80, "R3 overflow flag set on wrap");
      rd_chk(6'h04, 8'hFF, 8'h00, "R3 counter wrapped to zero");

      cur_req = "R8";
      rd_chk(6'h05, 8'h00, 8'h00, "R8 counter read access");
      bus_write(6'h05, 8'h33);
      rd_chk(6'h0F, 8'hFF, 8'h80, "R8 flag kept without fast clear");

      cur_req = "R5";
      bus_write(6'h0F, 8'h00);
      rd_chk(6'h0F, 8'hFF, 8'h80, "R5 write zero keeps flag");
      bus_write(6'h0F, 8'h80);
      rd_chk(6'h0F, 8'hFF, 8'h00, "R5 write one clears flag");
      check("R4 irq follows flag", 16'(irq), 16'h0);

      cur_req = "R4";
      bus_write(6'h0D, 8'h00);
      load_cnt(16'hFFF0);
      idle(30);
      rd_chk(6'h0F, 8'hFF, 8'h80, "R4 flag set with interrupt off");
      check("R4 irq masked", 16'(irq), 16'h0);
      bus_write(6'h0F, 8'h80);

      cur_req = "R6";
      load_cnt(16'hFFF0);
      bus_write(6'h06, 8'h90);
      idle(30);
      rd_chk(6'h0F, 8'hFF, 8'h80, "R6 flag set before fast clear");
      rd_chk(6'h04, 8'h00, 8'h00, "R6 counter access");
      rd_chk(6'h0F, 8'hFF, 8'h00, "R6 fast clear by counter read");

      cur_req = "R2";
      bus_write(6'h06, 8'h00);
      load_cnt(16'h0000);
      bus_write(6'h0D, 8'h05);
      bus_write(6'h06, 8'h80);
      idle(5);
      bus_read(6'h05, a);
      idle(62);
      bus_read(6'h05, b);
      check("R2 two ticks in 64 cycles at exponent 5", 16'(b - a), 16'h2);

      cur_req = "R10";
      bus_write(6'h06, 8'h00);
      load_cnt(16'h0000);
      bus_write(6'h0D, 8'h08);
      bus_write(6'h0C, 8'h82);
      bus_write(6'h1E, 8'h00);
      bus_write(6'h1F, 8'h10);
      bus_write(6'h12, 8'h00);
      bus_write(6'h13, 8'h05);
      bus_write(6'h0E, 8'hFF);
      bus_write(6'h06, 8'h80);
      idle(60);
      for (int i = 0; i < 12; i++) begin
         bus_read(6'h05, a);
         check("R10 counter stays at or below match", 16'(a <= 8'h10), 16'h1);
      end
      rd_chk(6'h04, 8'hFF, 8'h00, "R10 high byte stays zero");

      cur_req = "R11";
      rd_chk(6'h0E, 8'hFF, 8'h82, "R11 compare flags set");
      @(negedge clk); cap = 8'h04;
      @(negedge clk); cap = 8'h00;
      rd_chk(6'h0E, 8'h04, 8'h04, "R11 capture flag set");
      rd_chk(6'h14, 8'hFF, 8'h00, "R11 captured high byte");

      cur_req = "R12";
      @(negedge clk); addr = 6'h0E; wdata = 8'h08; wr = 1'b1; cap = 8'h08;
      @(negedge clk); wr = 1'b0; cap = 8'h00;
      rd_chk(6'h0E, 8'h08, 8'h08, "R12 set beats clear");
      bus_write(6'h0E, 8'h08);
      rd_chk(6'h0E, 8'h08, 8'h00, "R12 later clear succeeds");

      cur_req = "R13";
      bus_write(6'h06, 8'hA0);
      @(negedge clk); dbg = 1'b1;
      bus_read(6'h05, a);
      idle(10);
      bus_read(6'h05, b);
      check("R13 frozen in debug", 16'(b), 16'(a));
      @(negedge clk); dbg = 1'b0;
      bus_write(6'h06, 8'hC0);
      @(negedge clk); wt = 1'b1;
      bus_read(6'h05, a);
      idle(10);
      bus_read(6'h05, b);
      check("R13 frozen in wait", 16'(b), 16'(a));
      @(negedge clk); dbg = 1'b1;
      bus_read(6'h05, a);
      idle(1);
      @(negedge clk); wt = 1'b0;
      bus_read(6'h05, b);
      check("R13 debug ignored without its halt bit", 16'(b != a), 16'h1);
      @(negedge clk); dbg = 1'b0;

      cur_req = "R7";
      bus_write(6'h06, 8'h10);
      rd_chk(6'h0E, 8'h06, 8'h06, "R7 both flags set before fast clear");
      rd_chk(6'h13, 8'h00, 8'h00, "R8 compare channel read");
      rd_chk(6'h0E, 8'h02, 8'h02, "R8 compare read keeps flag");
      bus_write(6'h12, 8'h00);
      rd_chk(6'h0E, 8'h02, 8'h00, "R7 compare write clears flag");
      bus_write(6'h14, 8'h00);
      rd_chk(6'h0E, 8'h04, 8'h04, "R8 capture write keeps flag");
      rd_chk(6'h15, 8'h00, 8'h00, "R7 capture channel read");
      rd_chk(6'h0E, 8'h04, 8'h00, "R7 capture read clears flag");

      idle(3);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule